// File: doc/BRIEF.md
# Root Port Interrupt Aggregator

This block gathers the interrupt sources of one PCIe root port into a single interrupt line. It has 32 sources. The four lowest sources are legacy INTx wires and are level-sensitive: their status bits follow the input wire directly. Every other source is an edge event, such as link up (bit 12), link down (bit 14), bandwidth management (bit 11), completion timeout (bit 23), a requester-ID map error (bit 22), a tunnel error (bit 31) or the error group in bits 4 to 7. A rising edge on one of these sources latches its status bit, and the bit stays set until software clears it.

Software reaches four registers over a small single-cycle register bus. It reads the pending status and acknowledges edge events by writing ones to the status register. It changes the mask through two strobe registers, one that sets mask bits and one that clears them, so no read-modify-write is needed. The mask can be read back at its own address. The interrupt output is high while any source is both pending and unmasked. After reset every source is masked and nothing is pending, which is the state a driver creates at initialisation.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset all mask bits read as one, all edge status bits read as zero, and `irq_o` is low.
- R2: Status bits 0 to 3 show the current level of `src_i[3:0]` in the same cycle, with no latching.
- R3: Writing ones to status bits 0 to 3 has no effect. Those bits keep following their inputs.
- R4: A rising edge on any source from bit 4 upward sets its status bit at the next clock edge. The bit stays set after the source falls.
- R5: A write to the status register clears each edge status bit where the write data holds a one. Bits where the write data holds a zero are unchanged.
- R6: If a rising edge and a clearing write reach the same edge bit in the same cycle, the bit stays set.
- R7: A write to the mask-set register sets each mask bit where the write data holds a one. All other mask bits are unchanged.
- R8: A write to the mask-clear register clears each mask bit where the write data holds a one. All other mask bits are unchanged.
- R9: Status bits latch and report events whether or not the source is masked.
- R10: `irq_o` is high exactly when some status bit is set and its mask bit is clear. The level sources reach `irq_o` in the same cycle.
- R11: An edge source that stays high after its bit has been cleared does not set the bit again until it falls and rises once more.
- R12: Address 0 reads the status and address 1 reads the mask. Reads of address 2 (mask-set) and address 3 (mask-clear) return zero, and `rdata_o` is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt sources; bits 0 to 3 are level, the rest are edge |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 mask-set, 3 mask-clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the read request |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The hardest case to reach from the ports is a source that rises in exactly the cycle in which software's clearing write to the same bit takes effect. The bench drives the new source level and the bus write in the same half-cycle, so both arrive at one clock edge. It then reads the status back to confirm that the event survived. A second hard case is a source held high across an acknowledge. The bench clears the bit while the wire stays high, waits several cycles and reads the status back to confirm that the bit did not return.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_MSET = 2'd2,
    REG_MCLR = 2'd3
  } reg_sel_e;

  localparam int unsigned REG_AW = 2;

  // source bit positions that other logic decodes
  localparam int unsigned SRC_BW_MGMT   = 11;
  localparam int unsigned SRC_LINK_UP   = 12;
  localparam int unsigned SRC_LINK_DOWN = 14;
  localparam int unsigned SRC_MAP_ERR   = 22;
  localparam int unsigned SRC_CPL_TMO   = 23;
  localparam int unsigned SRC_TUN_ERR   = 31;
  localparam int unsigned SRC_ERR_LO    = 4;
  localparam int unsigned SRC_ERR_HI    = 7;
endpackage

// File: rtl/pirq_src_stage.sv
module pirq_src_stage #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_LVL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] prev_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g < NUM_LVL) begin : g_lvl
      logic unused_clr;
      assign unused_clr = clr_i[g];
      assign stat_o[g]  = src_i[g];
      assign prev_o[g]  = 1'b0;
    end else begin : g_edge
      logic prev_q, stat_q, rise;
      assign rise = src_i[g] & ~prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          stat_q <= 1'b0;
        end else begin
          prev_q <= src_i[g];
          // a new edge wins over a same-cycle clear
          stat_q <= (stat_q & ~clr_i[g]) | rise;
        end
      end
      assign stat_o[g] = stat_q;
      assign prev_o[g] = prev_q;
    end
  end
endmodule

// File: rtl/pirq_mask_reg.sv
module pirq_mask_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '1;
    else if (set_i) mask_q <= mask_q | data_i;
    else if (clr_i) mask_q <= mask_q & ~data_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pirq_regif.sv
module pirq_regif
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic               mset_o,
  output logic               mclr_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  reg_sel_e sel;
  logic     wr, rd;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;

  assign stat_clr_o = (wr && sel == REG_STAT) ? wdata_i : '0;
  assign mset_o     = wr && sel == REG_MSET;
  assign mclr_o     = wr && sel == REG_MCLR;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_STAT: rdata_o = stat_i;
        REG_MASK: rdata_o = mask_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_LVL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_w, prev_w, mask_w, stat_clr_w;
  logic               mset_w, mclr_w;

  pirq_regif #(.NUM_SRC(NUM_SRC)) u_regif (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stat_i     (stat_w),
    .mask_i     (mask_w),
    .stat_clr_o (stat_clr_w),
    .mset_o     (mset_w),
    .mclr_o     (mclr_w),
    .rdata_o    (rdata_o)
  );

  pirq_src_stage #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (stat_clr_w),
    .stat_o (stat_w),
    .prev_o (prev_w)
  );

  pirq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mset_w),
    .clr_i  (mclr_w),
    .data_i (wdata_i),
    .mask_o (mask_w)
  );

  assign irq_o = |(stat_w & ~mask_w);
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_LVL = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [REG_AW-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] prev
);
  localparam logic [NUM_SRC-1:0] EDGE_MSK =
    {{(NUM_SRC-NUM_LVL){1'b1}}, {NUM_LVL{1'b0}}};

  logic wr_stat, wr_set, wr_clr;
  logic [NUM_SRC-1:0] rise;
  assign wr_stat = req_i && we_i && addr_i == REG_STAT;
  assign wr_set  = req_i && we_i && addr_i == REG_MSET;
  assign wr_clr  = req_i && we_i && addr_i == REG_MCLR;
  assign rise    = src_i & ~prev & EDGE_MSK;

  // R4 R6
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((stat & $past(rise)) == $past(rise)));

  // R5
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((stat & $past(wdata_i & EDGE_MSK & ~rise)) == '0));

  // R3
  lvl_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> (stat[NUM_LVL-1:0] == src_i[NUM_LVL-1:0]));

  // R7
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask & $past(wdata_i)) == $past(wdata_i)));

  // R8
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask & $past(wdata_i)) == '0));

  // R10
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |-> !irq_o);
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .src_i   (src_i),
  .irq_o   (irq_o),
  .stat    (stat_w),
  .mask    (mask_w),
  .prev    (prev_w)
);

// File: tb/sim_pirq_ctrl.sv
module sim_pirq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pirq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(2'd1, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    bus_rd(2'd0, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    bus_rd(2'd2, d); chk("R12 mset read", d, 32'h0);
    bus_rd(2'd3, d); chk("R12 mclr read", d, 32'h0);
    #1 chk("R12 idle rdata", rdata_o, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk_i); src_i[2] = 1'b1;
    bus_rd(2'd0, d); chk("R2 level high", d, 32'h4);
    bus_wr(2'd0, 32'hF);
    bus_rd(2'd0, d); chk("R3 w1c ignored", d, 32'h4);
    @(negedge clk_i); src_i[2] = 1'b0;
    bus_rd(2'd0, d); chk("R2 level low", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk_i); src_i[12] = 1'b1;
    @(negedge clk_i); src_i[12] = 1'b0;
    bus_rd(2'd0, d); chk("R4 latched", d, 32'h1000);
    chk("R9 masked no irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i); src_i[14] = 1'b1;
    @(negedge clk_i); src_i[14] = 1'b0;
    bus_wr(2'd0, 32'h1000);
    bus_rd(2'd0, d); chk("R5 partial clear", d, 32'h4000);
    bus_wr(2'd0, 32'h4000);
    bus_rd(2'd0, d); chk("R5 all clear", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk_i);
    src_i[22] = 1'b1;
    req_i = 1'b1; we_i = 1'b1; addr_i = 2'd0; wdata_i = 32'h40_0000;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0; src_i[22] = 1'b0;
    bus_rd(2'd0, d); chk("R6 edge beats clear", d, 32'h40_0000);
    bus_wr(2'd0, 32'h40_0000);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    @(negedge clk_i); src_i[23] = 1'b1;
    bus_rd(2'd0, d); chk("R11 first event", d, 32'h80_0000);
    bus_wr(2'd0, 32'h80_0000);
    repeat (3) @(negedge clk_i);
    bus_rd(2'd0, d); chk("R11 no relatch", d, 32'h0);
    @(negedge clk_i); src_i[23] = 1'b0;
    @(negedge clk_i); src_i[23] = 1'b1;
    bus_rd(2'd0, d); chk("R11 new edge", d, 32'h80_0000);
    @(negedge clk_i); src_i[23] = 1'b0;
    bus_wr(2'd0, 32'h80_0000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    @(negedge clk_i); src_i[31] = 1'b1;
    @(negedge clk_i); src_i[31] = 1'b0;
    #1 chk("R9 pending while masked", {31'h0, irq_o}, 32'h0);
    bus_wr(2'd3, 32'h8000_0002);
    bus_rd(2'd1, d); chk("R8 mask clear", d, 32'h7FFF_FFFD);
    #1 chk("R10 irq unmasked", {31'h0, irq_o}, 32'h1);
    bus_wr(2'd2, 32'h8000_0000);
    bus_rd(2'd1, d); chk("R7 mask set", d, 32'hFFFF_FFFD);
    #1 chk("R10 irq remasked", {31'h0, irq_o}, 32'h0);
    src_i[1] = 1'b1;
    #1 chk("R10 level irq", {31'h0, irq_o}, 32'h1);
    src_i[1] = 1'b0;
    #1 chk("R10 level irq drop", {31'h0, irq_o}, 32'h0);
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, d); chk("R12 mask addr read-only", d, 32'hFFFF_FFFD);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_level();
    t_edge();
    t_collide();
    t_hold();
    t_mask();
    finish_up();
  end
endmodule